// File: doc/BRIEF.md
# Lookup-Table Wall-Following Robot Controller

This block steers a maze-walking robot that keeps its right feeler against a wall. Two contact sensors (left and right, each high while touching) feed a four-state controller. The controller drives three actuator commands: step forward, pivot left by a small angle and pivot right by a small angle. The robot's drive logic samples these commands once per clock.

All next-state and command logic is held in one lookup table. The table has 2^(state bits + sensor bits) words of (state bits + command bits). The address is the present state followed by the left and right sensor bits. Each word holds the next state and the three command bits. The table is computed at elaboration from a small policy function. One register captures the whole word on every rising edge, so the state and the commands both come straight from flops.

A command describes the state in which the sensors were sampled. It appears on the outputs one clock after that sampling edge.

Top module: `wallbot_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the state output to 00 (seeking) and drives all three commands low, starting at the first rising edge taken while reset is high.
- R2: The state output uses the codes seeking=00, pivoting=01, hugging-outward=10 and hugging-inward=11. The table address is {state[1], state[0], left, right}.
- R3: In seeking (00), the state stays 00 when neither sensor touches. It moves to pivoting (01) when either sensor or both touch.
- R4: In pivoting (01), the state moves to hugging-outward (10) only when both sensors read 0. Every other sensor pattern keeps it in 01.
- R5: In hugging-outward (10), right=1 moves the state to hugging-inward (11) and right=0 keeps it in 10. The left sensor has no effect on the next state.
- R6: In hugging-inward (11), left=1 moves the state to pivoting (01). left=0 with right=0 moves it to hugging-outward (10). left=0 with right=1 keeps it in 11.
- R7: The commands are registered with the next state and reflect the state held before the edge. The pairs are: seeking gives step only; pivoting gives pivot-left only; hugging-outward gives pivot-right plus step; hugging-inward gives pivot-left plus step. Each table word is {next[1], next[0], pivot-right, pivot-left, step}.
- R8: Pivot-left and pivot-right are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| touch_left | input | 1 | Left contact sensor, 1 while touching |
| touch_right | input | 1 | Right contact sensor, 1 while touching |
| fwd_step | output | 1 | Step-forward command |
| turn_left | output | 1 | Pivot-left command |
| turn_right | output | 1 | Pivot-right command |
| mode_state | output | 2 | Present controller state |

## Verification
The bench builds the block with its default sizes: two sensor bits, two state bits and three command bits, which gives a 16-word table of 5-bit words. At these sizes the table is small enough to test completely. Each of the 16 words is reached by steering the controller into its start state and then applying one sensor pattern, and both the next state and the command pair are checked. Directed runs then cover reset taken from a non-zero state, repeated holds in seeking, and the left sensor toggling while in hugging-outward.

// File: rtl/wallbot_pkg.sv
`timescale 1ns/1ps
package wallbot_pkg;

    localparam int SENSE_W = 2;
    localparam int STATE_W = 2;
    localparam int CMD_W   = 3;
    localparam int ADDR_W  = STATE_W + SENSE_W;
    localparam int WORD_W  = STATE_W + CMD_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        ST_SEEK    = 2'b00,
        ST_PIVOT   = 2'b01,
        ST_HUG_OUT = 2'b10,
        ST_HUG_IN  = 2'b11
    } wb_state_t;

    // bit order matters: word is {next, pivot-right, pivot-left, step}
    typedef struct packed {
        logic tr;
        logic tl;
        logic fwd;
    } wb_cmd_t;

    typedef struct packed {
        wb_state_t nxt;
        wb_cmd_t   cmd;
    } wb_word_t;

    // Policy: address = {state, left, right}
    function automatic wb_word_t wb_policy(input logic [ADDR_W-1:0] a);
        wb_word_t  w;
        wb_state_t s;
        logic      l;
        logic      r;
        s = wb_state_t'(a[ADDR_W-1:SENSE_W]);
        l = a[1];
        r = a[0];
        w = '0;
        case (s)
            ST_SEEK: begin
                w.cmd = '{tr: 1'b0, tl: 1'b0, fwd: 1'b1};
                w.nxt = (l || r) ? ST_PIVOT : ST_SEEK;
            end
            ST_PIVOT: begin
                w.cmd = '{tr: 1'b0, tl: 1'b1, fwd: 1'b0};
                w.nxt = (!l && !r) ? ST_HUG_OUT : ST_PIVOT;
            end
            ST_HUG_OUT: begin
                w.cmd = '{tr: 1'b1, tl: 1'b0, fwd: 1'b1};
                w.nxt = r ? ST_HUG_IN : ST_HUG_OUT;
            end
            default: begin
                w.cmd = '{tr: 1'b0, tl: 1'b1, fwd: 1'b1};
                if (l)      w.nxt = ST_PIVOT;
                else if (r) w.nxt = ST_HUG_IN;
                else        w.nxt = ST_HUG_OUT;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wallbot_table.sv
`timescale 1ns/1ps
module wallbot_table
    import wallbot_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = WORD_W
) (
    input  logic [A_W-1:0] addr_i,
    output logic [D_W-1:0] word_o
);
    localparam int N_WORDS = 1 << A_W;

    logic [D_W-1:0] rom [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        assign rom[i] = D_W'(wb_policy(ADDR_W'(i)));
    end

    assign word_o = rom[addr_i];
endmodule

// File: rtl/wallbot_regs.sv
`timescale 1ns/1ps
module wallbot_regs
    import wallbot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wb_word_t  word_i,
    output wb_state_t state_o,
    output wb_cmd_t   cmd_o
);
    typedef struct packed {
        wb_state_t st;
        wb_cmd_t   cmd;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d.st  = word_i.nxt;
        r_d.cmd = word_i.cmd;
        if (rst) begin
            r_d.st  = ST_SEEK;
            r_d.cmd = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_o = r_q.st;
    assign cmd_o   = r_q.cmd;
endmodule

// File: rtl/wallbot_ctrl.sv
`timescale 1ns/1ps
module wallbot_ctrl
    import wallbot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       touch_left,
    input  logic       touch_right,
    output logic       fwd_step,
    output logic       turn_left,
    output logic       turn_right,
    output logic [1:0] mode_state
);
    wb_state_t          state_q;
    wb_cmd_t            cmd_q;
    logic [ADDR_W-1:0]  tbl_addr;
    logic [WORD_W-1:0]  tbl_word;

    assign tbl_addr = {state_q, touch_left, touch_right};

    wallbot_table #(.A_W(ADDR_W), .D_W(WORD_W)) u_table (
        .addr_i (tbl_addr),
        .word_o (tbl_word)
    );

    wallbot_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .word_i  (wb_word_t'(tbl_word)),
        .state_o (state_q),
        .cmd_o   (cmd_q)
    );

    assign fwd_step   = cmd_q.fwd;
    assign turn_left  = cmd_q.tl;
    assign turn_right = cmd_q.tr;
    assign mode_state = state_q;

    // R3
    lost_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEEK && (touch_left || touch_right)) |=> state_q == ST_PIVOT);

    // R4
    pivot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PIVOT && (touch_left || touch_right)) |=> state_q == ST_PIVOT);

    // R5
    hug_out_left_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUG_OUT && !touch_right) |=> state_q == ST_HUG_OUT);

    // R6
    hug_in_left_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUG_IN && touch_left) |=> state_q == ST_PIVOT);

    // R7
    pivot_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PIVOT) |=> (turn_left && !turn_right && !fwd_step));

    // R8
    turn_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(turn_left && turn_right));
endmodule

// File: tb/wallbot_ctrl_tb.sv
`timescale 1ns/1ps
module wallbot_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tl_in = 1'b0;
    logic tr_in = 1'b0;
    logic fwd, tleft, tright;
    logic [1:0] st;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wallbot_ctrl u_dut (
        .clk (clk), .rst (rst),
        .touch_left (tl_in), .touch_right (tr_in),
        .fwd_step (fwd), .turn_left (tleft), .turn_right (tright),
        .mode_state (st)
    );

    // {start[1:0], left, right, next[1:0], pivot-right, pivot-left, step}
    localparam logic [8:0] VEC [16] = '{
        9'b00_00_00_001, 9'b00_01_01_001, 9'b00_10_01_001, 9'b00_11_01_001,
        9'b01_00_10_010, 9'b01_01_01_010, 9'b01_10_01_010, 9'b01_11_01_010,
        9'b10_00_10_101, 9'b10_01_11_101, 9'b10_10_10_101, 9'b10_11_11_101,
        9'b11_00_10_011, 9'b11_01_11_011, 9'b11_10_01_011, 9'b11_11_01_011
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // every call starts and ends just after a falling edge
    task automatic step(input logic l, input logic r);
        tl_in = l;
        tr_in = r;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic go_to(input logic [1:0] s);
        do_reset();
        if (s != 2'b00) step(1'b1, 1'b0);
        if (s[1])       step(1'b0, 1'b0);
        if (s == 2'b11) step(1'b0, 1'b1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 R2: reset state
        check("R1", {st, tright, tleft, fwd}, 5'b00_000);
        rst = 1'b0;

        // exhaustive table walk, R3..R6 by start state, R7 commands, R8 exclusivity
        for (int i = 0; i < 16; i++) begin
            logic [8:0] v;
            string      tag;
            v = VEC[i];
            case (v[8:7])
                2'b00:   tag = "R3";
                2'b01:   tag = "R4";
                2'b10:   tag = "R5";
                default: tag = "R6";
            endcase
            go_to(v[8:7]);
            check("R2", {3'b000, st}, {3'b000, v[8:7]});
            step(v[6], v[5]);
            check(tag,  {3'b000, st}, {3'b000, v[4:3]});
            check("R7", {2'b00, tright, tleft, fwd}, {2'b00, v[2:0]});
            check("R8", {4'b0000, tleft & tright}, 5'b00000);
        end

        // R1: reset from hugging-inward with both sensors touching
        go_to(2'b11);
        rst = 1'b1;
        step(1'b1, 1'b1);
        check("R1", {st, tright, tleft, fwd}, 5'b00_000);
        rst = 1'b0;

        // R3: hold in seeking over several cycles, step stays asserted
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R3", {st, tright, tleft, fwd}, 5'b00_001);

        // R5: toggle left sensor in hugging-outward, state must not move
        go_to(2'b10);
        for (int k = 0; k < 4; k++) begin
            step(k[0], 1'b0);
            check("R5", {st, tright, tleft, fwd}, 5'b10_101);
        end

        // R6 then R4: inward -> pivot via left, pivot held while right touches
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        check("R6", {3'b000, st}, 5'b00001);
        step(1'b0, 1'b1);
        check("R4", {st, tright, tleft, fwd}, 5'b01_010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule